// File: doc/BRIEF.md
# Controller Interrupt and Reset Sequencer

This block keeps the interrupt-pending state of a four-drive floppy-style disk controller and produces the two result bytes of a sense-interrupt-status command. Raise requests carry an 8-bit status-0 value that is remembered for later reporting. Clear requests retire a pending interrupt. A controller reset leaves one pending interrupt behind, and the next four sense commands then report a ready-change status for each drive in turn.

The surrounding controller supplies the currently selected drive number, head and track, and issues one-cycle strobes. Only one request is acted on in a given cycle, chosen by a fixed priority. The results are registered. They appear on the cycle after a sense strobe and hold until the next honoured sense.

Top module: `fdc_irq_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `irq_out` and `sra_pend` are 0, `sense_st0` and `sense_pcn` are 0x00 and the replay counter is zero, so a sense returns the seek-end form.
- R2: A honoured raise makes `irq_out` and `sra_pend` 1 on the next cycle. A raise while already pending leaves them at 1.
- R3: Every honoured raise records its status byte, even when an interrupt is already pending. A later sense returns it if bit 4 (equipment check, 0x10) is set.
- R4: A honoured clear drops `irq_out` and `sra_pend` to 0 on the next cycle when pending. When nothing is pending it has no visible effect.
- R5: A controller reset request leaves `irq_out` and `sra_pend` at 1, loads the replay counter with the drive count (4) and records ready-change (0xC0).
- R6: While the replay counter is nonzero, each sense returns ST0 = 0xC0 + (4 − counter) and decrements the counter. After a reset this gives 0xC0, 0xC1, 0xC2, 0xC3.
- R7: With the counter at zero and bit 4 of the recorded status clear, ST0 = 0x20 | (head << 2) | drive, with the drive number in bits 1:0.
- R8: With the counter at zero and the recorded status having bit 4 set, ST0 equals the recorded status byte.
- R9: The second result byte equals `cur_track` as sampled with the sense strobe. Both result bytes update one cycle after an honoured sense and otherwise hold their value.
- R10: After every honoured sense the recorded status returns to 0xC0.
- R11: A honoured raise forces the replay counter to zero.
- R12: Priority in one cycle is controller reset, then raise, then clear, then sense. Requests that lose are ignored entirely.
- R13: A sense command changes neither `irq_out` nor `sra_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| ctl_reset_req | input | 1 | Controller reset request strobe |
| raise_req | input | 1 | Raise-interrupt request strobe |
| raise_status | input | 8 | Status-0 value carried by a raise |
| clear_req | input | 1 | Clear-interrupt request strobe |
| sense_req | input | 1 | Sense-interrupt-status command strobe |
| cur_drive | input | DRV_W (2) | Currently selected drive number |
| cur_head | input | 1 | Current head of the selected drive |
| cur_track | input | 8 | Current track of the selected drive |
| irq_out | output | 1 | Interrupt line |
| sra_pend | output | 1 | Pending bit as seen in bit 7 of status register A |
| sense_st0 | output | 8 | First sense result byte (ST0) |
| sense_pcn | output | 8 | Second sense result byte (present cylinder) |

## Verification
The assertions rely on every strobe and the drive, head and track inputs being known (never X) at each sampling edge. They do not assume the strobes are exclusive, because the priority encoder resolves overlaps. The stimulus changes inputs only on the falling edge and holds drive, head and track steady across each sense strobe. Overlapping strobes are applied deliberately, only in the directed priority tests.

// File: rtl/fdc_irq_pkg.sv
package fdc_irq_pkg;

    localparam logic [7:0] ST0_READY_CHG = 8'hC0;
    localparam logic [7:0] ST0_ABN_TERM  = 8'h40;
    localparam logic [7:0] ST0_SEEK_END  = 8'h20;
    localparam logic [7:0] ST0_EQUIP_CHK = 8'h10;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_CTL_RESET,
        ACT_RAISE,
        ACT_CLEAR,
        ACT_SENSE
    } irq_action_e;

    typedef struct packed {
        logic [7:0] st0;
        logic [7:0] pcn;
    } sense_result_t;

    // fixed priority: controller reset > raise > clear > sense
    function automatic irq_action_e pick_action(input logic rs, input logic ra,
                                                input logic cl, input logic se);
        if (rs)      return ACT_CTL_RESET;
        else if (ra) return ACT_RAISE;
        else if (cl) return ACT_CLEAR;
        else if (se) return ACT_SENSE;
        else         return ACT_NONE;
    endfunction

    function automatic logic [7:0] seek_st0(input logic head, input logic [7:0] drv);
        return ST0_SEEK_END | {5'b0, head, 2'b00} | drv;
    endfunction

endpackage

// File: rtl/irq_pending_flag.sv
module irq_pending_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic pending
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)          pend_q <= 1'b0;
        else if (set_req) pend_q <= 1'b1;
        else if (clr_req) pend_q <= 1'b0;
    end

    assign pending = pend_q;

    a_r2_set_makes_pending: assert property (@(posedge clk) disable iff (rst)
        set_req |=> pending);
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_req) |=> !pending);
    a_r13_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!set_req && !clr_req) |=> $stable(pending));
endmodule

// File: rtl/sense_seq_counter.sv
module sense_seq_counter #(
    parameter int unsigned NUM_DRIVES = 4,
    parameter int unsigned CNT_W      = $clog2(NUM_DRIVES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             zero,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             active
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_DRIVES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (load)                    cnt_q <= FULL;
        else if (zero)                    cnt_q <= '0;
        else if (dec && (cnt_q != '0))    cnt_q <= cnt_q - 1'b1;
    end

    assign count  = cnt_q;
    assign active = (cnt_q != '0);

    a_r5_load_full: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == FULL));
    a_r11_raise_zeroes: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> !active);
    a_r6_step_down: assert property (@(posedge clk) disable iff (rst)
        (dec && active && !load && !zero) |=> (count == $past(count) - 1'b1));
    a_r6_bounded: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);
endmodule

// File: rtl/sense_result_gen.sv
module sense_result_gen
    import fdc_irq_pkg::*;
#(
    parameter int unsigned NUM_DRIVES = 4,
    parameter int unsigned DRV_W      = 2,
    parameter int unsigned CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             record_en,
    input  logic [7:0]       record_val,
    input  logic             sense_en,
    input  logic [CNT_W-1:0] replay_cnt,
    input  logic             replay_active,
    input  logic [DRV_W-1:0] drive,
    input  logic             head,
    input  logic [7:0]       track,
    output sense_result_t    result
);
    logic [7:0]       status_q;
    sense_result_t    res_q, res_d;
    logic [CNT_W-1:0] replay_idx;

    assign replay_idx = CNT_W'(NUM_DRIVES) - replay_cnt;

    always_comb begin
        res_d = res_q;
        if (sense_en) begin
            res_d.pcn = track;
            if (replay_active)
                res_d.st0 = ST0_READY_CHG | 8'(replay_idx);
            else if ((status_q & ST0_EQUIP_CHK) != 8'h00)
                res_d.st0 = status_q;
            else
                res_d.st0 = seek_st0(head, 8'(drive));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= ST0_READY_CHG;
            res_q    <= '0;
        end else begin
            res_q <= res_d;
            if (record_en)     status_q <= record_val;
            else if (sense_en) status_q <= ST0_READY_CHG;
        end
    end

    assign result = res_q;

    a_r9_pcn_tracks: assert property (@(posedge clk) disable iff (rst)
        sense_en |=> (result.pcn == $past(track)));
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !sense_en |=> $stable(result));
    a_r10_back_to_ready: assert property (@(posedge clk) disable iff (rst)
        (sense_en && !record_en) |=> (status_q == ST0_READY_CHG));
endmodule

// File: rtl/fdc_irq_seq.sv
module fdc_irq_seq
    import fdc_irq_pkg::*;
#(
    parameter int unsigned NUM_DRIVES = 4,
    parameter int unsigned DRV_W      = $clog2(NUM_DRIVES),
    parameter int unsigned CNT_W      = $clog2(NUM_DRIVES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_reset_req,
    input  logic             raise_req,
    input  logic [7:0]       raise_status,
    input  logic             clear_req,
    input  logic             sense_req,
    input  logic [DRV_W-1:0] cur_drive,
    input  logic             cur_head,
    input  logic [7:0]       cur_track,
    output logic             irq_out,
    output logic             sra_pend,
    output logic [7:0]       sense_st0,
    output logic [7:0]       sense_pcn
);
    irq_action_e      act;
    logic             do_reset, do_raise, do_clear, do_sense;
    logic             pending;
    logic [CNT_W-1:0] replay_cnt;
    logic             replay_active;
    logic [7:0]       rec_val;
    sense_result_t    result;

    assign act      = pick_action(ctl_reset_req, raise_req, clear_req, sense_req);
    assign do_reset = (act == ACT_CTL_RESET);
    assign do_raise = (act == ACT_RAISE);
    assign do_clear = (act == ACT_CLEAR);
    assign do_sense = (act == ACT_SENSE);
    // a controller reset clears then re-raises, so the net effect is a set
    assign rec_val  = do_reset ? ST0_READY_CHG : raise_status;

    irq_pending_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (do_reset | do_raise),
        .clr_req (do_clear),
        .pending (pending)
    );

    sense_seq_counter #(
        .NUM_DRIVES (NUM_DRIVES),
        .CNT_W      (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (do_reset),
        .zero   (do_raise),
        .dec    (do_sense),
        .count  (replay_cnt),
        .active (replay_active)
    );

    sense_result_gen #(
        .NUM_DRIVES (NUM_DRIVES),
        .DRV_W      (DRV_W),
        .CNT_W      (CNT_W)
    ) u_res (
        .clk           (clk),
        .rst           (rst),
        .record_en     (do_reset | do_raise),
        .record_val    (rec_val),
        .sense_en      (do_sense),
        .replay_cnt    (replay_cnt),
        .replay_active (replay_active),
        .drive         (cur_drive),
        .head          (cur_head),
        .track         (cur_track),
        .result        (result)
    );

    assign irq_out   = pending;
    assign sra_pend  = pending;
    assign sense_st0 = result.st0;
    assign sense_pcn = result.pcn;

    a_r12_reset_wins: assert property (@(posedge clk) disable iff (rst)
        ctl_reset_req |=> (irq_out && $stable(sense_st0) && $stable(sense_pcn)));
    a_r13_sense_keeps_irq: assert property (@(posedge clk) disable iff (rst)
        (sense_req && !ctl_reset_req && !raise_req && !clear_req) |=> $stable(irq_out));
    a_r6_replay_code: assert property (@(posedge clk) disable iff (rst)
        (do_sense && replay_active) |=> ((sense_st0 & 8'hFC) == ST0_READY_CHG));
endmodule

// File: tb/test_fdc_irq_seq.sv
`timescale 1ns/1ps
module test_fdc_irq_seq;

    typedef struct packed {
        logic [2:0] op;      // 0 idle, 1 ctl reset, 2 raise, 3 clear, 4 sense
        logic [7:0] val;
        logic [1:0] drv;
        logic       hd;
        logic [7:0] trk;
        logic       e_irq;
        logic [7:0] e_st0;
        logic [7:0] e_pcn;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 8'h00, 2'd0, 1'b0, 8'd0,  1'b1, 8'h00, 8'd0,  4'd5},  // R5 reset pends
        '{3'd4, 8'h00, 2'd1, 1'b0, 8'd5,  1'b1, 8'hC0, 8'd5,  4'd6},  // R6 first replay, R13
        '{3'd4, 8'h00, 2'd1, 1'b0, 8'd6,  1'b1, 8'hC1, 8'd6,  4'd6},  // R6
        '{3'd3, 8'h00, 2'd0, 1'b0, 8'd0,  1'b0, 8'hC1, 8'd6,  4'd4},  // R4 clear, R9 hold
        '{3'd4, 8'h00, 2'd1, 1'b0, 8'd7,  1'b0, 8'hC2, 8'd7,  4'd6},  // R6
        '{3'd4, 8'h00, 2'd1, 1'b0, 8'd8,  1'b0, 8'hC3, 8'd8,  4'd6},  // R6 last replay
        '{3'd4, 8'h00, 2'd2, 1'b1, 8'd9,  1'b0, 8'h26, 8'd9,  4'd7},  // R7
        '{3'd3, 8'h00, 2'd0, 1'b0, 8'd0,  1'b0, 8'h26, 8'd9,  4'd4},  // R4 no effect
        '{3'd2, 8'h50, 2'd0, 1'b0, 8'd0,  1'b1, 8'h26, 8'd9,  4'd2},  // R2
        '{3'd4, 8'h00, 2'd3, 1'b0, 8'd10, 1'b1, 8'h50, 8'd10, 4'd8},  // R8
        '{3'd4, 8'h00, 2'd0, 1'b1, 8'd11, 1'b1, 8'h24, 8'd11, 4'd10}, // R10
        '{3'd2, 8'h20, 2'd0, 1'b0, 8'd0,  1'b1, 8'h24, 8'd11, 4'd2},  // R2 already pending
        '{3'd2, 8'h70, 2'd0, 1'b0, 8'd0,  1'b1, 8'h24, 8'd11, 4'd3},  // R3
        '{3'd4, 8'h00, 2'd1, 1'b0, 8'd12, 1'b1, 8'h70, 8'd12, 4'd3},  // R3 recorded while pending
        '{3'd1, 8'h00, 2'd0, 1'b0, 8'd0,  1'b1, 8'h70, 8'd12, 4'd5},  // R5
        '{3'd4, 8'h00, 2'd0, 1'b0, 8'd1,  1'b1, 8'hC0, 8'd1,  4'd6},  // R6
        '{3'd2, 8'h00, 2'd0, 1'b0, 8'd0,  1'b1, 8'hC0, 8'd1,  4'd11}, // R11
        '{3'd4, 8'h00, 2'd3, 1'b1, 8'd2,  1'b1, 8'h27, 8'd2,  4'd11}, // R11 replay cut
        '{3'd3, 8'h00, 2'd0, 1'b0, 8'd0,  1'b0, 8'h27, 8'd2,  4'd4}   // R4
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_reset_req = 1'b0, raise_req = 1'b0, clear_req = 1'b0, sense_req = 1'b0;
    logic [7:0] raise_status = 8'h00;
    logic [1:0] cur_drive = 2'd0;
    logic       cur_head = 1'b0;
    logic [7:0] cur_track = 8'd0;
    logic       irq_out, sra_pend;
    logic [7:0] sense_st0, sense_pcn;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fdc_irq_seq i_fdc_irq_seq (
        .clk           (clk),
        .rst           (rst),
        .ctl_reset_req (ctl_reset_req),
        .raise_req     (raise_req),
        .raise_status  (raise_status),
        .clear_req     (clear_req),
        .sense_req     (sense_req),
        .cur_drive     (cur_drive),
        .cur_head      (cur_head),
        .cur_track     (cur_track),
        .irq_out       (irq_out),
        .sra_pend      (sra_pend),
        .sense_st0     (sense_st0),
        .sense_pcn     (sense_pcn)
    );

    task automatic check(input int req, input logic e_irq,
                         input logic [7:0] e_st0, input logic [7:0] e_pcn);
        n_chk++;
        if (irq_out !== e_irq || sra_pend !== e_irq ||
            sense_st0 !== e_st0 || sense_pcn !== e_pcn) begin
            n_fail++;
            $display("FAIL R%0d: irq=%b pend=%b st0=%h pcn=%h, expected irq=%b pend=%b st0=%h pcn=%h",
                     req, irq_out, sra_pend, sense_st0, sense_pcn, e_irq, e_irq, e_st0, e_pcn);
        end
    endtask

    // drive at negedge, let one rising edge sample, return at next negedge
    task automatic step(input logic rs, input logic ra, input logic [7:0] v,
                        input logic cl, input logic se, input logic [1:0] d,
                        input logic h, input logic [7:0] t);
        ctl_reset_req = rs; raise_req = ra; raise_status = v;
        clear_req = cl; sense_req = se;
        cur_drive = d; cur_head = h; cur_track = t;
        @(posedge clk);
        @(negedge clk);
        ctl_reset_req = 1'b0; raise_req = 1'b0; clear_req = 1'b0; sense_req = 1'b0;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(1, 1'b0, 8'h00, 8'h00);                     // R1 reset state

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].op == 3'd1, VECS[i].op == 3'd2, VECS[i].val,
                 VECS[i].op == 3'd3, VECS[i].op == 3'd4,
                 VECS[i].drv, VECS[i].hd, VECS[i].trk);
            check(int'(VECS[i].req), VECS[i].e_irq, VECS[i].e_st0, VECS[i].e_pcn);
        end

        // R12: all four at once, controller reset wins, results held
        step(1'b1, 1'b1, 8'h50, 1'b1, 1'b1, 2'd1, 1'b0, 8'd33);
        check(12, 1'b1, 8'h27, 8'd2);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 1'b0, 8'd33);
        check(12, 1'b1, 8'hC0, 8'd33);                    // R12 raise lost: replay intact

        // R12: clear beats sense
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 1'b0, 8'd99);
        check(12, 1'b0, 8'hC0, 8'd33);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd0, 1'b0, 8'd34);
        check(12, 1'b0, 8'hC1, 8'd34);                    // R12 lost sense did not count

        // R12: raise beats clear
        step(1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 2'd0, 1'b0, 8'd0);
        check(12, 1'b1, 8'hC1, 8'd34);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd2, 1'b0, 8'd40);
        check(11, 1'b1, 8'h22, 8'd40);                    // R11 counter zeroed by raise

        // R1: block reset mid-run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(1, 1'b0, 8'h00, 8'h00);
        rst = 1'b0;
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 1'b1, 8'd7);
        check(1, 1'b0, 8'h25, 8'd7);                      // R1 counter zero, R13 irq stays low

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule